// File: doc/BRIEF.md
# Parallel Lookup-Table Waveform Predistorter

This block turns a stored bit pattern into multi-level drive samples for an optical modulator, handling a whole 64-bit word of the sequence on every clock. A pattern memory is read word by word in address order. Each read word is joined with the tail of the word before it, so that a window of n bits can slide across the word boundary. Sixty-four identical tables each take one n-bit slice of that window and return an 8-bit entry. The entry holds two 4-bit samples for that bit position. Because the tables are arbitrary, any linear or nonlinear response of up to n bits of memory can be programmed.

The sixty-four table outputs are transposed into eight 64-bit lane words, one for each downstream serializer lane. Table k drives bit k of every lane. Tables and pattern are loaded through one address/data/write-enable port while the block sits in its load state. Raising the run enable starts the readout.

The controller has two states. LOAD accepts writes and holds the outputs not valid. RUN reads the pattern and produces lane words. The START transition takes LOAD to RUN when the run enable is high: it clears the read address and the history. The STOP transition takes RUN back to LOAD when the run enable is low: it drops the output valid. Both states otherwise hold.

Top module: `wave_lut_predistorter`

## Requirements
- R1: After reset the block is in LOAD, `out_valid` is low and every bit of `lane_words` is zero.
- R2: In LOAD, a write with `cfg_tgt`=0 stores `cfg_data[7:0]` at entry `cfg_addr[n-1:0]` of all 64 tables at once. A write with `cfg_tgt`=1 stores the 64-bit `cfg_data` as pattern word `cfg_addr[PAT_AW-1:0]`.
- R3: Writes issued while in RUN change neither the tables, the pattern nor the pattern length.
- R4: START happens on the rising edge where `run_en` is sampled high in LOAD. The first pattern word is read on the next edge, and its lane words appear with `out_valid` high after the edge after that, which is the third edge counting START.
- R5: Pattern words are read at consecutive addresses from 0. After the last word the read wraps back to address 0. The last word is the address of the most recent pattern write, and it is 0 after reset.
- R6: For output bit k, the table address bit n-1 is bit k of the current word, and address bit b is the stream bit n-1-b positions earlier. Positions before bit 0 come from the top bits of the previous word, so that bit 63 of the previous word is one position before bit 0.
- R7: The first word after START sees zeros as its previous-word history.
- R8: Lane j bit k equals bit j of the entry returned by table k. Lanes 0 to 3 therefore carry the first sample (low nibble) from LSB to MSB, and lanes 4 to 7 carry the second sample (high nibble).
- R9: While in RUN with `run_en` high, `out_valid` stays high on every cycle once it has risen. STOP lowers `out_valid` after the edge that samples `run_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High to run the readout, low to return to the load state |
| cfg_we | input | 1 | Write strobe for tables or pattern |
| cfg_tgt | input | 1 | Write target: 0 for the tables, 1 for the pattern memory |
| cfg_addr | input | max(PAT_AW, LUT_AW) | Table entry or pattern word address |
| cfg_data | input | WORD_W | Pattern word, or a table entry in the low 8 bits |
| out_valid | output | 1 | Marks lane words that carry pattern data |
| lane_words | output | 8*WORD_W | Eight lane words; lane j occupies bits j*WORD_W upward |

## Verification
A wrong read address or wrap point shows up at the ports as a whole lane word from the wrong pattern entry, two clocks after the bad read. A history register that is stale or not cleared corrupts only bit positions below n-1, and only on the word that follows the fault. The bench therefore uses patterns whose top and bottom bits differ. A swapped nibble or lane mapping misplaces bits on every valid cycle. A valid flag with the wrong timing is caught on the cycle when START or STOP takes effect, because every cycle is compared with a model that counts edges since START.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } wlp_state_e;

    localparam int SAMPLE_W  = 4;
    localparam int SAMPLE_N  = 2;
    localparam int ENTRY_W   = SAMPLE_W * SAMPLE_N;
    localparam int LANE_CNT  = ENTRY_W;
endpackage

// File: rtl/wlp_pattern_mem.sv
module wlp_pattern_mem #(
    parameter int WORD_W = 64,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= mem[raddr];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/wlp_table.sv
module wlp_table #(
    parameter int ADDR_W  = 4,
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic               re,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= mem[raddr];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/wlp_window.sv
module wlp_window #(
    parameter int WORD_W = 64,
    parameter int LUT_AW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       adv,
    input  logic [WORD_W-1:0]          word,
    output logic [WORD_W+LUT_AW-2:0]   ext,
    output logic [LUT_AW-2:0]          hist
);
    localparam int TAIL_W = LUT_AW - 1;

    logic [TAIL_W-1:0] tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else if (clr) begin
            tail_q <= '0;
        end else if (adv) begin
            tail_q <= word[WORD_W-1 -: TAIL_W];
        end
    end

    assign ext  = {word, tail_q};
    assign hist = tail_q;
endmodule

// File: rtl/wlp_ctrl.sv
module wlp_ctrl
    import wlp_pkg::*;
#(
    parameter int PAT_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic              cfg_tgt,
    input  logic [PAT_AW-1:0] cfg_pat_addr,
    output logic              pat_we,
    output logic              tbl_we,
    output logic              pat_re,
    output logic [PAT_AW-1:0] rd_addr,
    output logic              hist_clr,
    output logic              stage2_en,
    output logic              out_valid
);
    wlp_state_e        state_q, state_d;
    logic [PAT_AW-1:0] last_q;
    logic [PAT_AW-1:0] addr_q;
    logic              v1_q, v2_q;
    logic              load_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_LOAD;
            default: state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_wr  = 1'b0;
        pat_re   = 1'b0;
        hist_clr = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_wr  = cfg_we;
                hist_clr = run_en;
            end
            ST_RUN: begin
                pat_re = run_en;
            end
            default: begin
                load_wr = 1'b0;
            end
        endcase
        pat_we = load_wr & cfg_tgt;
        tbl_we = load_wr & ~cfg_tgt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            addr_q <= '0;
            v1_q   <= 1'b0;
            v2_q   <= 1'b0;
        end else begin
            if (pat_we) begin
                last_q <= cfg_pat_addr;
            end
            if (hist_clr) begin
                addr_q <= '0;
            end else if (pat_re) begin
                addr_q <= (addr_q == last_q) ? '0 : addr_q + 1'b1;
            end
            v1_q <= pat_re;
            v2_q <= pat_re & v1_q;
        end
    end

    assign rd_addr   = addr_q;
    assign stage2_en = v1_q;
    assign out_valid = v2_q;

    a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(last_q));

    a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        v2_q |-> $past(v1_q));

    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (addr_q <= last_q));

    a_r9_load_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !v2_q);
endmodule

// File: rtl/wave_lut_predistorter.sv
module wave_lut_predistorter
    import wlp_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int LUT_AW = 4,
    parameter int PAT_AW = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          run_en,
    input  logic                                          cfg_we,
    input  logic                                          cfg_tgt,
    input  logic [((PAT_AW > LUT_AW) ? PAT_AW : LUT_AW)-1:0] cfg_addr,
    input  logic [WORD_W-1:0]                             cfg_data,
    output logic                                          out_valid,
    output logic [LANE_CNT*WORD_W-1:0]                    lane_words
);
    localparam int EXT_W = WORD_W + LUT_AW - 1;

    logic              pat_we, tbl_we, pat_re, hist_clr, stage2_en;
    logic [PAT_AW-1:0] rd_addr;
    logic [WORD_W-1:0] word_q;
    logic [EXT_W-1:0]  ext;
    logic [LUT_AW-2:0] hist;
    logic [ENTRY_W-1:0] ent [WORD_W];

    wlp_ctrl #(.PAT_AW(PAT_AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .cfg_we       (cfg_we),
        .cfg_tgt      (cfg_tgt),
        .cfg_pat_addr (cfg_addr[PAT_AW-1:0]),
        .pat_we       (pat_we),
        .tbl_we       (tbl_we),
        .pat_re       (pat_re),
        .rd_addr      (rd_addr),
        .hist_clr     (hist_clr),
        .stage2_en    (stage2_en),
        .out_valid    (out_valid)
    );

    wlp_pattern_mem #(.WORD_W(WORD_W), .AW(PAT_AW)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pat_we),
        .waddr (cfg_addr[PAT_AW-1:0]),
        .wdata (cfg_data),
        .re    (pat_re),
        .raddr (rd_addr),
        .rdata (word_q)
    );

    wlp_window #(.WORD_W(WORD_W), .LUT_AW(LUT_AW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hist_clr),
        .adv   (stage2_en),
        .word  (word_q),
        .ext   (ext),
        .hist  (hist)
    );

    for (genvar k = 0; k < WORD_W; k++) begin : g_tbl
        wlp_table #(.ADDR_W(LUT_AW), .ENTRY_W(ENTRY_W)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tbl_we),
            .waddr (cfg_addr[LUT_AW-1:0]),
            .wdata (cfg_data[ENTRY_W-1:0]),
            .re    (stage2_en),
            .raddr (ext[k +: LUT_AW]),
            .rdata (ent[k])
        );
        for (genvar j = 0; j < LANE_CNT; j++) begin : g_lane
            assign lane_words[j*WORD_W + k] = ent[k][j];
        end
    end

    // R7: first consumed word after START sees a cleared history
    a_r7_hist_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage2_en) |-> (hist == '0));
endmodule

// File: tb/tb_wave_lut_predistorter.sv
module tb_wave_lut_predistorter;
    localparam int CLK_PERIOD = 10;
    localparam int WW  = 64;
    localparam int NA  = 4;
    localparam int PA  = 4;
    localparam int LN  = 8;
    localparam int CAW = (PA > NA) ? PA : NA;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               run_en = 1'b0;
    logic               cfg_we = 1'b0;
    logic               cfg_tgt = 1'b0;
    logic [CAW-1:0]     cfg_addr = '0;
    logic [WW-1:0]      cfg_data = '0;
    logic               out_valid;
    logic [LN*WW-1:0]   lane_words;

    int errors = 0;
    int checks = 0;
    int edges  = 0;

    logic [7:0]    tbl_m [1 << NA];
    logic [WW-1:0] pat_m [1 << PA];
    int            last_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_lut_predistorter #(.WORD_W(WW), .LUT_AW(NA), .PAT_AW(PA)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cfg_we     (cfg_we),
        .cfg_tgt    (cfg_tgt),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .out_valid  (out_valid),
        .lane_words (lane_words)
    );

    task automatic check(input string req, input logic [LN*WW-1:0] act,
                         input logic [LN*WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [LN*WW-1:0] model_out(input int idx);
        logic [LN*WW-1:0] res;
        logic [WW-1:0]    w, prev;
        int               len;
        len  = last_m + 1;
        w    = pat_m[idx % len];
        prev = (idx == 0) ? '0 : pat_m[(idx - 1) % len];
        res  = '0;
        for (int k = 0; k < WW; k++) begin
            int a = 0;
            for (int b = 0; b < NA; b++) begin
                int  pos = k - (NA - 1) + b;
                logic bitv = (pos >= 0) ? w[pos] : prev[WW + pos];
                if (bitv) a = a | (1 << b);
            end
            for (int j = 0; j < LN; j++) res[j*WW + k] = tbl_m[a][j];
        end
        return res;
    endfunction

    task automatic load_write(input logic tgt, input int addr, input logic [WW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tgt = tgt; cfg_addr = CAW'(addr); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (tgt) begin
            pat_m[addr] = data;
            last_m = addr;
        end else begin
            tbl_m[addr] = data[7:0];
        end
    endtask

    // model-driven run: compares valid and data on every cycle
    task automatic run_cycles(input int n, input bit junk, input string req);
        for (int c = 0; c < n; c++) begin
            if (junk) begin
                cfg_we = 1'b1; cfg_tgt = c[0];
                cfg_addr = CAW'(c); cfg_data = {WW{1'b1}} ^ WW'(c * 7919);
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
            check({req, " R4 R9 valid"}, LN*WW'(out_valid), LN*WW'(edges >= 3));
            if (edges >= 3)
                check({req, " R6 R8 data"}, lane_words, model_out(edges - 3));
        end
        cfg_we = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk);
        run_en = 1'b1;
        edges = 0;
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 stop drops valid", LN*WW'(out_valid), '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", LN*WW'(out_valid), '0);
        check("R1 reset lanes", lane_words, '0);

        // R2: table contents, broadcast to all tables
        for (int a = 0; a < (1 << NA); a++)
            load_write(1'b0, a, WW'((a * 29 + 7) & 255));
        // R2 R5: six-word pattern, last write at address 5
        load_write(1'b1, 0, 64'h0000_0000_0000_0000);
        load_write(1'b1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        load_write(1'b1, 2, 64'h5555_5555_5555_5555);
        load_write(1'b1, 3, 64'h0123_4567_89AB_CDEF);
        load_write(1'b1, 4, 64'h8000_0000_0000_0001);
        load_write(1'b1, 5, 64'hF0E1_D2C3_B4A5_9687);
        check("R1 load holds not valid", LN*WW'(out_valid), '0);

        // R4 R5 R6 R7 R8: run across several wraps
        start_run();
        run_cycles(10, 1'b0, "R5 wrap");
        // R3: writes during run are ignored
        run_cycles(12, 1'b1, "R3 ignored");
        stop_run();

        // R5: last written address defines length (write order 2,1,0)
        for (int a = 0; a < (1 << NA); a++)
            load_write(1'b0, a, WW'(((a * 113) ^ 8'hA5) & 255));
        load_write(1'b1, 2, 64'h1111_2222_3333_4444);
        load_write(1'b1, 1, 64'h8421_8421_8421_8421);
        load_write(1'b1, 0, 64'hC000_0000_0000_0003);
        start_run();
        run_cycles(7, 1'b0, "R5 R7 single word");
        stop_run();

        // R5: two-word pattern, restart clears history again (R7)
        load_write(1'b1, 1, 64'h7FFF_0000_FFFF_0001);
        start_run();
        run_cycles(8, 1'b0, "R5 R7 two words");
        stop_run();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule